// File: doc/BRIEF.md
# Byte-serial CRC-16 / CRC-32 Checksum Engine

The engine keeps a running CRC over a stream of bytes and presents the result in a register that software reads. Data reaches it from one of two places. Software can write words into a data-input register over a simple register bus. Alternatively, a DMA-style beat stream with a valid/ready handshake can feed it, and each beat carries its own size. A control register selects the source, the polynomial (CRC-16 with 0x1021 or CRC-32 with 0x04C11DB7) and the beat size used for bus writes. Each beat is broken into bytes, lowest byte first, and the CRC absorbs one byte per clock cycle.

A status flag marks a computation in progress. Hardware sets it when the first byte of a new computation is taken. Software clears it by writing 1 to it. The clear finalises the result: for CRC-32 the checksum register then shows the running value bit-reversed and inverted, and for CRC-16 it shows the raw value. While the flag is set, the checksum register shows the raw running value. The reset input is asynchronous and active low. It is assumed to be released synchronously to `clk` upstream.

Register map (word index on `bus_addr`): 0 control, 1 data input, 2 status, 3 checksum.

Top module: `crc_bus_engine`

## Requirements
- R1: After reset, control reads 0, status reads 0 and checksum reads 0x0000FFFF. Control bit 0 selects the polynomial (0 = CRC-16, 1 = CRC-32), bit 1 selects the source (0 = bus data input, 1 = stream), and bits 3:2 hold the bus beat size. Writing control loads the preset value of the newly chosen polynomial and ends any computation.
- R2: CRC-16 uses polynomial 0x1021 with preset 0xFFFF. Each byte is shifted in most significant bit first. For bytes 0x31..0x39 the result is 0x29B1, and the checksum register reads it unmodified both before and after finalisation.
- R3: CRC-32 uses polynomial 0x04C11DB7 with preset 0xFFFFFFFF. While busy is set, the checksum reads the raw running value (0x0376E6E7 for bytes 0x31..0x39). After finalisation it reads the bit-reversed and inverted value (0x1898913F for the same bytes).
- R4: Only the selected source feeds the CRC. A data-input write while the stream is selected changes neither busy nor the checksum. While the bus is selected, `dma_ready` stays low.
- R5: The beat-size encoding is 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. It comes from control bits 3:2 for bus writes and from `dma_size` for each stream beat. A beat's bytes are taken from least to most significant.
- R6: One byte is absorbed per cycle. After a 4-byte stream beat is accepted, `dma_ready` is low for exactly 4 cycles. `bus_ready` is low while bytes remain, and a bus write is held until it rises.
- R7: Status bit 0 (busy) reads 1 from the cycle after the first byte of a new computation is accepted.
- R8: Writing 1 to status bit 0 while busy clears busy and finalises the result in the next cycle. After that, data-input writes are ignored and the checksum stays stable until a new computation starts.
- R9: A stream beat accepted after finalisation starts a new computation from the preset value and sets busy again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on `bus_addr`) |
| bus_ready | output | 1 | Low while a beat is still being consumed; a write waits |
| dma_valid | input | 1 | Stream beat valid |
| dma_data | input | 32 | Stream beat data |
| dma_size | input | 2 | Stream beat size code |
| dma_ready | output | 1 | Stream beat accepted when high with `dma_valid` |

## Verification
The hardest situation to reach is the finalised state followed by more traffic. Two cases arise there: a bus data write that must be dropped, and a stream beat that must restart the computation from the preset. The bench reaches them by completing a full nine-byte message, clearing busy over the bus, confirming the finalised value, and only then issuing the extra write or beat. The byte-order rule is exercised by sending the same nine bytes as a mix of 4-, 2- and 1-byte stream beats and requiring the same CRC-16 as byte-by-byte bus writes.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int          BUS_W     = 32;
  localparam int          ADDR_W    = 2;
  localparam logic [15:0] POLY16    = 16'h1021;
  localparam logic [31:0] POLY32    = 32'h04C11DB7;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_CHK  = 2'd3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } beat_size_e;

  typedef struct packed {
    logic [1:0] size;
    logic       src_stream;
    logic       poly32;
  } ctrl_t;

  function automatic logic [31:0] crc_preset(input logic poly32);
    return poly32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] bit_rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic [W-1:0] crc_in,
  input  logic [7:0]   byte_in,
  output logic [W-1:0] crc_out
);

  always_comb begin
    logic [W-1:0] c;
    logic         fb;
    c = crc_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[W-1] ^ byte_in[i];
      c  = {c[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_out = c;
  end

endmodule

// File: rtl/crc_beat_unpack.sv
module crc_beat_unpack #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [CNT_W-1:0]  load_cnt,
  output logic [7:0]        byte_out,
  output logic              byte_vld,
  output logic [CNT_W-1:0]  pend_cnt
);

  logic [DATA_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              buf_en;

  assign byte_vld = (cnt_q != '0);
  assign byte_out = buf_q[7:0];
  assign pend_cnt = cnt_q;
  assign buf_en   = load | byte_vld;

  always_comb begin
    buf_d = buf_q;
    cnt_d = cnt_q;
    if (load) begin
      buf_d = load_data;
      cnt_d = load_cnt;
    end else if (byte_vld) begin
      buf_d = buf_q >> 8;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/crc_bus_engine.sv
module crc_bus_engine
  import crc_pkg::*;
#(
  parameter int DATA_W = BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic              dma_valid,
  input  logic [DATA_W-1:0] dma_data,
  input  logic [1:0]        dma_size,
  output logic              dma_ready
);

  localparam int NBYTES = DATA_W / 8;
  localparam int CNT_W  = $clog2(NBYTES + 1);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t       ctrl_q, ctrl_d;
  logic        busy_q, busy_d;
  logic        fin_q, fin_d;
  logic [31:0] crc_q, crc_d;
  logic        state_en;

  logic              bus_wr, ctrl_wr, din_wr, stat_clr, dma_acc;
  logic              beat_acc, start;
  logic [1:0]        beat_size;
  logic [DATA_W-1:0] beat_data;
  logic [CNT_W-1:0]  beat_cnt, pend_cnt;
  logic [7:0]        cur_byte;
  logic              byte_vld;
  logic [15:0]       step16;
  logic [31:0]       step32;
  logic [31:0]       chk_val;

  // ---- request decode ----
  assign bus_ready = !byte_vld;
  assign bus_wr    = bus_sel && bus_write && bus_ready;
  assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
  assign din_wr    = bus_wr && (bus_addr == A_DIN) && !ctrl_q.src_stream && !fin_q;
  assign stat_clr  = bus_wr && (bus_addr == A_STAT) && bus_wdata[0] && busy_q;
  assign dma_ready = ctrl_q.src_stream && !byte_vld && !(bus_sel && bus_write);
  assign dma_acc   = dma_valid && dma_ready;
  assign beat_acc  = din_wr || dma_acc;
  assign start     = beat_acc && !busy_q;

  assign beat_size = ctrl_q.src_stream ? dma_size : ctrl_q.size;
  assign beat_data = ctrl_q.src_stream ? dma_data : bus_wdata;

  always_comb begin
    case (beat_size_e'(beat_size))
      SZ_BYTE: beat_cnt = CNT_W'(1);
      SZ_HALF: beat_cnt = CNT_W'((NBYTES >= 2) ? 2 : NBYTES);
      default: beat_cnt = CNT_W'(NBYTES);
    endcase
  end

  // ---- beat to byte splitter ----
  crc_beat_unpack #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (beat_acc),
    .load_data (beat_data),
    .load_cnt  (beat_cnt),
    .byte_out  (cur_byte),
    .byte_vld  (byte_vld),
    .pend_cnt  (pend_cnt)
  );

  // ---- per-byte CRC update, one per polynomial ----
  crc_byte_step #(.W(16), .POLY(POLY16)) u_step16 (
    .crc_in  (crc_q[15:0]),
    .byte_in (cur_byte),
    .crc_out (step16)
  );

  crc_byte_step #(.W(32), .POLY(POLY32)) u_step32 (
    .crc_in  (crc_q),
    .byte_in (cur_byte),
    .crc_out (step32)
  );

  // ---- next state ----
  always_comb begin
    ctrl_d = ctrl_q;
    busy_d = busy_q;
    fin_d  = fin_q;
    crc_d  = crc_q;
    if (ctrl_wr) begin
      ctrl_d = ctrl_t'(bus_wdata[CTRL_W-1:0]);
      busy_d = 1'b0;
      fin_d  = 1'b0;
      crc_d  = crc_preset(bus_wdata[0]);
    end else if (start) begin
      busy_d = 1'b1;
      fin_d  = 1'b0;
      crc_d  = crc_preset(ctrl_q.poly32);
    end else if (stat_clr) begin
      busy_d = 1'b0;
      fin_d  = 1'b1;
    end else if (byte_vld) begin
      crc_d  = ctrl_q.poly32 ? step32 : {16'h0000, step16};
    end
  end

  assign state_en = ctrl_wr || start || stat_clr || byte_vld;

  // ---- registers ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      crc_q  <= 32'h0000_FFFF;
    end else if (state_en) begin
      ctrl_q <= ctrl_d;
      busy_q <= busy_d;
      fin_q  <= fin_d;
      crc_q  <= crc_d;
    end
  end

  // ---- checksum view and read mux ----
  always_comb begin
    if (ctrl_q.poly32) chk_val = fin_q ? ~bit_rev32(crc_q) : crc_q;
    else               chk_val = {16'h0000, crc_q[15:0]};
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      A_STAT:  bus_rdata = DATA_W'(busy_q);
      A_CHK:   bus_rdata = DATA_W'(chk_val);
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/crc_bus_engine_chk.sv
module crc_bus_engine_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_ready,
  input logic             dma_ready,
  input logic             dma_valid,
  input logic [1:0]       dma_size,
  input logic             src_stream,
  input logic             poly32,
  input logic             busy_q,
  input logic             fin_q,
  input logic             start,
  input logic             stat_clr,
  input logic             ctrl_wr,
  input logic [31:0]      crc_q,
  input logic [CNT_W-1:0] pend_cnt
);

  // R7
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  // R8
  fin_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (fin_q && !busy_q));

  // R8
  fin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && !start && !ctrl_wr) |=> $stable(crc_q));

  // R6
  bus_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt != '0) |-> !bus_ready);

  // R6
  dma_word_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_ready && dma_size[1]) |=> !dma_ready);

  // R4
  src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_stream |-> !dma_ready);

  // R9
  start_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (crc_q == (poly32 ? 32'hFFFF_FFFF : 32'h0000_FFFF)));

endmodule

bind crc_bus_engine crc_bus_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_ready  (bus_ready),
  .dma_ready  (dma_ready),
  .dma_valid  (dma_valid),
  .dma_size   (dma_size),
  .src_stream (ctrl_q.src_stream),
  .poly32     (ctrl_q.poly32),
  .busy_q     (busy_q),
  .fin_q      (fin_q),
  .start      (start),
  .stat_clr   (stat_clr),
  .ctrl_wr    (ctrl_wr),
  .crc_q      (crc_q),
  .pend_cnt   (pend_cnt)
);

// File: tb/tb_crc_bus_engine.sv
`timescale 1ns/1ps
module tb_crc_bus_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_write;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready;
  logic        dma_valid;
  logic [31:0] dma_data;
  logic [1:0]  dma_size;
  logic        dma_ready;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  crc_bus_engine dut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .dma_valid(dma_valid), .dma_data(dma_data), .dma_size(dma_size),
    .dma_ready(dma_ready)
  );

  typedef struct packed {
    logic        poly32;
    logic        stream;
    logic [1:0]  size;
    logic [1:0]  nw;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] w2;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd2, 2'd3, 32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF},
    '{1'b1, 1'b0, 2'd1, 2'd2, 32'h0000A55A, 32'h0000FFFF, 32'h00000000},
    '{1'b1, 1'b1, 2'd2, 2'd3, 32'h00000000, 32'hFFFFFFFF, 32'h12345678},
    '{1'b0, 1'b1, 2'd0, 2'd2, 32'h000000AB, 32'h000000CD, 32'h00000000},
    '{1'b1, 1'b0, 2'd0, 2'd1, 32'h00000080, 32'h00000000, 32'h00000000},
    '{1'b0, 1'b0, 2'd1, 2'd3, 32'h00001234, 32'h00005678, 32'h00009ABC}
  };

  // ---- reference model from the requirement text ----
  function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b,
                                           input logic p32);
    for (int i = 7; i >= 0; i--) begin
      if (p32) c = (c[31] ^ b[i]) ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
      else     c = {16'h0, (c[15] ^ b[i]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0}};
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_beat(input logic [31:0] c, input logic [31:0] w,
                                           input logic [1:0] sz, input logic p32);
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++) c = ref_byte(c, w[8*k +: 8], p32);
    return c;
  endfunction

  function automatic logic [31:0] ref_final(input logic [31:0] c, input logic p32);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = c[31-i];
    return p32 ? ~r : {16'h0, c[15:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic dma_send(input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    dma_valid = 1'b1; dma_data = d; dma_size = sz;
    while (!dma_ready) @(negedge clk);
    @(negedge clk);
    dma_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, m;
    int n;
    rst_n = 1'b0;
    bus_sel = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    dma_valid = 0; dma_data = 0; dma_size = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(2'd0, rd); check("R1 ctrl reset", rd, 32'h0);
    bus_rd(2'd2, rd); check("R1 status reset", rd, 32'h0);
    bus_rd(2'd3, rd); check("R1 checksum reset", rd, 32'h0000FFFF);

    // ---- vector table ----
    for (int v = 0; v < NV; v++) begin
      m = VECS[v].poly32 ? 32'hFFFFFFFF : 32'h0000FFFF;
      bus_wr(2'd0, {28'h0, VECS[v].size, VECS[v].stream, VECS[v].poly32});
      for (int k = 0; k < int'(VECS[v].nw); k++) begin
        logic [31:0] w;
        w = (k == 0) ? VECS[v].w0 : (k == 1) ? VECS[v].w1 : VECS[v].w2;
        if (VECS[v].stream) dma_send(w, VECS[v].size);
        else                bus_wr(2'd1, w);
        m = ref_beat(m, w, VECS[v].size, VECS[v].poly32);
      end
      wait_idle();
      bus_rd(2'd2, rd); check("R7 busy in table", rd, 32'h1);
      bus_rd(2'd3, rd); check("R5 raw in table", rd, VECS[v].poly32 ? m : {16'h0, m[15:0]});
      bus_wr(2'd2, 32'h1);
      bus_rd(2'd3, rd); check("R3 final in table", rd, ref_final(m, VECS[v].poly32));
      bus_rd(2'd2, rd); check("R8 busy cleared in table", rd, 32'h0);
    end

    // R2 CRC-16 of bytes 0x31..0x39 over the bus
    bus_wr(2'd0, 32'h0);
    bus_rd(2'd2, rd); check("R1 ctrl write ends computation", rd, 32'h0);
    for (int b = 0; b < 9; b++) begin
      bus_wr(2'd1, 32'h31 + b);
      if (b == 0) begin bus_rd(2'd2, rd); check("R7 busy after first byte", rd, 32'h1); end
    end
    wait_idle();
    bus_rd(2'd3, rd); check("R2 crc16 raw", rd, 32'h000029B1);
    bus_wr(2'd2, 32'h1);
    bus_rd(2'd3, rd); check("R2 crc16 final", rd, 32'h000029B1);

    // R3 CRC-32 of the same bytes
    bus_wr(2'd0, 32'h1);
    for (int b = 0; b < 9; b++) bus_wr(2'd1, 32'h31 + b);
    wait_idle();
    bus_rd(2'd3, rd); check("R3 crc32 raw", rd, 32'h0376E6E7);
    bus_wr(2'd2, 32'h1);
    bus_rd(2'd3, rd); check("R3 crc32 final", rd, 32'h1898913F);
    // R8 data write after finalisation is ignored
    bus_wr(2'd1, 32'h55);
    wait_idle();
    bus_rd(2'd3, rd); check("R8 write after finalise ignored", rd, 32'h1898913F);
    bus_rd(2'd2, rd); check("R8 busy stays clear", rd, 32'h0);

    // R6 bus stall while a word is consumed (bus source, size word)
    bus_wr(2'd0, 32'h8);
    bus_wr(2'd1, 32'h11223344);
    check("R6 bus_ready low after word", {31'h0, bus_ready}, 32'h0);
    wait_idle();

    // R4 bus data write ignored while stream selected
    bus_wr(2'd0, 32'h2);
    bus_wr(2'd1, 32'hA5A5A5A5);
    wait_idle();
    bus_rd(2'd2, rd); check("R4 bus write ignored busy", rd, 32'h0);
    bus_rd(2'd3, rd); check("R4 bus write ignored crc", rd, 32'h0000FFFF);

    // R5 R2 mixed stream beats, lowest byte first, same bytes 0x31..0x39
    dma_send(32'h34333231, 2'd2);
    n = 0;
    while (!dma_ready) begin n++; @(negedge clk); end
    check("R6 dma_ready low cycles for word", n, 4);
    dma_send(32'h00003635, 2'd1);
    dma_send(32'h00000037, 2'd0);
    dma_send(32'h00000038, 2'd0);
    dma_send(32'hFFFFFF39, 2'd0);
    wait_idle();
    bus_rd(2'd3, rd); check("R5 mixed beats crc16", rd, 32'h000029B1);
    bus_wr(2'd2, 32'h1);
    bus_rd(2'd2, rd); check("R8 clear via status", rd, 32'h0);

    // R9 stream beat after finalisation restarts from preset
    dma_send(32'h00000031, 2'd0);
    wait_idle();
    bus_rd(2'd2, rd); check("R9 busy set on restart", rd, 32'h1);
    bus_rd(2'd3, rd); check("R9 restart from preset", rd, ref_byte(32'h0000FFFF, 8'h31, 1'b0));

    // R4 stream beats not accepted while bus selected
    bus_wr(2'd0, 32'h0);
    @(negedge clk);
    dma_valid = 1'b1; dma_data = 32'h12345678; dma_size = 2'd2;
    repeat (3) @(negedge clk);
    check("R4 dma_ready low with bus source", {31'h0, dma_ready}, 32'h0);
    dma_valid = 1'b0;
    bus_rd(2'd3, rd); check("R4 stream ignored crc", rd, 32'h0000FFFF);
    bus_rd(2'd2, rd); check("R4 stream ignored busy", rd, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule